// File: doc/BRIEF.md
# Line-Interface I/O Port Controller

This block drives a bank of general-purpose pins and a small set of select pins that connect to external line-interface circuits. A register bus configures it and reads it back. One configuration bit picks the operating mode.

In scan mode the block steps through the external devices in a fixed rotation. It raises one select line at a time and holds each line for a fixed number of clocks. While device n is selected, the pins marked as outputs carry that device's transmit word. At the end of the device's window, the pins marked as inputs are sampled into that device's receive word.

In direct mode the select pins stop selecting and become four more general-purpose pins. The meaning of the data registers changes in this mode. Any change seen on an input pin raises an interrupt request, which drives an open-drain line low. The request stays active until software reads the register that holds the changed input.

All pin inputs pass through a two-flop synchronizer. The block has an asynchronous active-low reset, which it releases synchronously inside the block.

Top module: `lio_port_ctrl`

## Requirements
- R1: While reset is held, sel_out is 4'b0001, sel_oe is 4'b1111, io_oe is 0 and irq_pd is 0. After reset, reading address 0 returns 0.
- R2: In scan mode (address 0 bit 15 = 0), sel_oe is all ones and exactly one sel_out bit is high. That bit moves 0→1→2→3→0, and each line stays high for SLOT_CYCLES (default 4) clocks.
- R3: Address 0 is the configuration register. Bits 11:0 give the direction of the 12 io pins (1 = output) and appear on io_oe in the cycle after the write. Bit 15 = 1 selects direct mode. A read returns the last value written.
- R4: In scan mode, while device n is selected, io_out carries bits 11:0 of data register n (address 1+n).
- R5: In scan mode, a read of address 1+n returns the io pin values captured at the end of device n's window. Bits of output-direction pins read 0, and bits 15:12 read 0.
- R6: In direct mode, bits 3:0 of data register 1 set sel_oe and bits 3:0 of data register 2 drive sel_out. A read of data register 1 returns its stored value. A read of data register 2 returns the synchronized sel_in pins in bits 3:0.
- R7: In direct mode, io_out carries bits 11:0 of data register 0, and a read of data register 0 returns the synchronized io_in pins.
- R8: A change on an input-direction pin sets irq_pd (1 = pull the line low). The change can be a newly captured device word in scan mode, or an io or sel pin in direct mode. irq_pd stays set until the register holding that input is read (data register n for device n; data register 0 for io pins, data register 2 for sel pins in direct mode). A change on an output-direction pin has no effect.
- R9: bus_rvalid is high exactly in the cycle after a read request, with bus_rdata valid in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Register access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register address (0 = config, 1..4 = data 0..3) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data |
| bus_rvalid | output | 1 | Read data valid |
| io_in | input | 12 | io pin input levels |
| io_out | output | 12 | io pin output levels |
| io_oe | output | 12 | io pin output enables |
| sel_in | input | 4 | Select pin input levels |
| sel_out | output | 4 | Select pin output levels |
| sel_oe | output | 4 | Select pin output enables |
| irq_pd | output | 1 | Interrupt pull-down enable for the open-drain line |

## Verification
Register writes reach io_out, io_oe, sel_out and sel_oe in the first cycle after the write edge. Read data appears one cycle after the request. The scoreboard therefore pops each expected read result exactly when bus_rvalid is seen.

Pin changes take two synchronizer cycles before they are visible. They take one more cycle before they raise irq_pd in direct mode. In scan mode they can wait up to a full rotation of N_DEV*SLOT_CYCLES clocks. The bench waits well past these bounds before it samples.

The rotation check first aligns itself to the first clock of device 1's window. It then samples one window per clock.

// File: rtl/lio_pkg.sv
package lio_pkg;
  // Data register roles when the block runs in direct mode
  localparam int ST_IO_VAL  = 0;
  localparam int ST_SEL_DIR = 1;
  localparam int ST_SEL_VAL = 2;
  // Configuration register address
  localparam int CFG_ADDR   = 0;
endpackage

// File: rtl/lio_sync.sv
module lio_sync #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d;
      s2_q <= s1_q;
    end
  end

  assign q = s2_q;
endmodule

// File: rtl/lio_scan.sv
module lio_scan #(
  parameter  int N_DEV       = 4,
  parameter  int SLOT_CYCLES = 4,
  localparam int SW          = (N_DEV > 1) ? $clog2(N_DEV) : 1,
  localparam int CW          = (SLOT_CYCLES > 1) ? $clog2(SLOT_CYCLES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  output logic [SW-1:0]    slot,
  output logic             last,
  output logic [N_DEV-1:0] sel
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic [SW-1:0] slot_q, slot_d;
  logic          end_win;

  assign end_win = run && (cnt_q == CW'(SLOT_CYCLES - 1));

  always_comb begin
    cnt_d  = cnt_q;
    slot_d = slot_q;
    if (!run) begin
      cnt_d  = '0;
      slot_d = '0;
    end else if (end_win) begin
      cnt_d  = '0;
      slot_d = (slot_q == SW'(N_DEV - 1)) ? '0 : slot_q + SW'(1);
    end else begin
      cnt_d  = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      slot_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      slot_q <= slot_d;
    end
  end

  for (genvar i = 0; i < N_DEV; i++) begin : g_sel
    assign sel[i] = (slot_q == SW'(i));
  end

  assign slot = slot_q;
  assign last = end_win;
endmodule

// File: rtl/lio_regs.sv
module lio_regs
  import lio_pkg::*;
#(
  parameter  int N_IO  = 12,
  parameter  int N_DEV = 4,
  parameter  int DW    = 16,
  localparam int SW    = (N_DEV > 1) ? $clog2(N_DEV) : 1,
  localparam int AW    = $clog2(N_DEV + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic             we,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wdata,
  input  logic [N_IO-1:0]  io_s,
  input  logic [N_DEV-1:0] sel_s,
  input  logic [SW-1:0]    slot,
  input  logic             cap,
  output logic [DW-1:0]    rdata,
  output logic             rvalid,
  output logic             mode,
  output logic [N_IO-1:0]  dir,
  output logic [N_IO-1:0]  io_drv,
  output logic [N_DEV-1:0] sel_oe_st,
  output logic [N_DEV-1:0] sel_val_st,
  output logic             irq
);
  logic [DW-1:0]    cfg_q;
  logic [DW-1:0]    tx_q   [N_DEV];
  logic [N_IO-1:0]  rx_q   [N_DEV];
  logic [N_IO-1:0]  rx_d   [N_DEV];
  logic [N_DEV-1:0] pend_q, pend_d;
  logic [N_IO-1:0]  io_prev_q;
  logic [N_DEV-1:0] sel_prev_q;
  logic [DW-1:0]    rdata_q, rd_val;
  logic             rvalid_q;

  logic             wr_hit, rd_hit, cfg_en;
  logic [N_DEV-1:0] tx_en;
  logic [N_IO-1:0]  cap_val, chg_io;
  logic [N_DEV-1:0] chg_sel;

  assign wr_hit = req && we;
  assign rd_hit = req && !we;
  assign cfg_en = wr_hit && (addr == AW'(CFG_ADDR));
  assign mode   = cfg_q[DW-1];
  assign dir    = cfg_q[N_IO-1:0];

  for (genvar n = 0; n < N_DEV; n++) begin : g_en
    assign tx_en[n] = wr_hit && (addr == AW'(n + 1));
  end

  // Input capture and change detection
  assign cap_val = io_s & ~dir;
  assign chg_io  = (io_s ^ io_prev_q) & ~dir;
  assign chg_sel = (sel_s ^ sel_prev_q) & ~tx_q[ST_SEL_DIR][N_DEV-1:0];

  always_comb begin
    for (int n = 0; n < N_DEV; n++) rx_d[n] = rx_q[n];
    if (!mode && cap) rx_d[slot] = cap_val;
  end

  always_comb begin
    for (int n = 0; n < N_DEV; n++) begin
      pend_d[n] = pend_q[n] && !(rd_hit && (addr == AW'(n + 1)));
      if (!mode && cap && (slot == SW'(n)) && (cap_val != rx_q[n])) pend_d[n] = 1'b1;
      if (mode && (n == ST_IO_VAL) && (|chg_io)) pend_d[n] = 1'b1;
      if (mode && (n == ST_SEL_VAL) && (|chg_sel)) pend_d[n] = 1'b1;
    end
  end

  // Read mux
  always_comb begin
    rd_val = '0;
    if (addr == AW'(CFG_ADDR)) rd_val = cfg_q;
    for (int n = 0; n < N_DEV; n++) begin
      if (addr == AW'(n + 1)) begin
        if (mode) begin
          if (n == ST_IO_VAL)       rd_val[N_IO-1:0]  = io_s;
          else if (n == ST_SEL_VAL) rd_val[N_DEV-1:0] = sel_s;
          else                      rd_val            = tx_q[n];
        end else begin
          rd_val[N_IO-1:0] = rx_q[n];
        end
      end
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (cfg_en) begin
      cfg_q <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int n = 0; n < N_DEV; n++) tx_q[n] <= '0;
    end else begin
      for (int n = 0; n < N_DEV; n++) if (tx_en[n]) tx_q[n] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int n = 0; n < N_DEV; n++) rx_q[n] <= '0;
      pend_q     <= '0;
      io_prev_q  <= '0;
      sel_prev_q <= '0;
    end else begin
      for (int n = 0; n < N_DEV; n++) rx_q[n] <= rx_d[n];
      pend_q     <= pend_d;
      io_prev_q  <= io_s;
      sel_prev_q <= sel_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd_hit;
      if (rd_hit) rdata_q <= rd_val;
    end
  end

  assign rdata      = rdata_q;
  assign rvalid     = rvalid_q;
  assign io_drv     = mode ? tx_q[ST_IO_VAL][N_IO-1:0] : tx_q[slot][N_IO-1:0];
  assign sel_oe_st  = tx_q[ST_SEL_DIR][N_DEV-1:0];
  assign sel_val_st = tx_q[ST_SEL_VAL][N_DEV-1:0];
  assign irq        = |pend_q;
endmodule

// File: rtl/lio_port_ctrl.sv
module lio_port_ctrl #(
  parameter  int N_IO        = 12,
  parameter  int N_DEV       = 4,
  parameter  int DW          = 16,
  parameter  int SLOT_CYCLES = 4,
  localparam int SW          = (N_DEV > 1) ? $clog2(N_DEV) : 1,
  localparam int AW          = $clog2(N_DEV + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_req,
  input  logic             bus_we,
  input  logic [AW-1:0]    bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  output logic             bus_rvalid,
  input  logic [N_IO-1:0]  io_in,
  output logic [N_IO-1:0]  io_out,
  output logic [N_IO-1:0]  io_oe,
  input  logic [N_DEV-1:0] sel_in,
  output logic [N_DEV-1:0] sel_out,
  output logic [N_DEV-1:0] sel_oe,
  output logic             irq_pd
);
  logic [1:0]       rst_sync_q;
  logic             rst_ni;
  logic [N_IO-1:0]  io_s;
  logic [N_DEV-1:0] sel_s;
  logic [SW-1:0]    slot;
  logic             cap;
  logic [N_DEV-1:0] scan_sel;
  logic             static_mode;
  logic [N_IO-1:0]  dir;
  logic [N_DEV-1:0] sel_oe_st, sel_val_st;

  // Asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  lio_sync #(.W(N_IO)) u_sync_io (
    .clk(clk), .rst_n(rst_ni), .d(io_in), .q(io_s)
  );

  lio_sync #(.W(N_DEV)) u_sync_sel (
    .clk(clk), .rst_n(rst_ni), .d(sel_in), .q(sel_s)
  );

  lio_scan #(.N_DEV(N_DEV), .SLOT_CYCLES(SLOT_CYCLES)) u_scan (
    .clk(clk), .rst_n(rst_ni), .run(!static_mode),
    .slot(slot), .last(cap), .sel(scan_sel)
  );

  lio_regs #(.N_IO(N_IO), .N_DEV(N_DEV), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_ni),
    .req(bus_req), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
    .io_s(io_s), .sel_s(sel_s), .slot(slot), .cap(cap),
    .rdata(bus_rdata), .rvalid(bus_rvalid),
    .mode(static_mode), .dir(dir), .io_drv(io_out),
    .sel_oe_st(sel_oe_st), .sel_val_st(sel_val_st), .irq(irq_pd)
  );

  assign io_oe   = dir;
  assign sel_out = static_mode ? sel_val_st : scan_sel;
  assign sel_oe  = static_mode ? sel_oe_st : '1;
endmodule

// File: rtl/lio_port_ctrl_chk.sv
module lio_port_ctrl_chk #(
  parameter  int N_IO        = 12,
  parameter  int N_DEV       = 4,
  parameter  int SLOT_CYCLES = 4,
  localparam int AW          = $clog2(N_DEV + 1)
) (
  input logic             clk,
  input logic             rst_ni,
  input logic             static_mode,
  input logic             bus_req,
  input logic             bus_we,
  input logic [AW-1:0]    bus_addr,
  input logic [N_IO-1:0]  wd_io,
  input logic             bus_rvalid,
  input logic [N_DEV-1:0] sel_out,
  input logic [N_DEV-1:0] sel_oe,
  input logic [N_IO-1:0]  io_oe,
  input logic             irq_pd
);
  logic [N_DEV-1:0] prev_sel_q;
  logic             prev_dyn_q;
  logic [15:0]      len_q;
  logic             armed_q;
  logic             sel_moved;

  assign sel_moved = !static_mode && prev_dyn_q && (sel_out != prev_sel_q);

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_sel_q <= '0;
      prev_dyn_q <= 1'b0;
      len_q      <= '0;
      armed_q    <= 1'b0;
    end else begin
      prev_sel_q <= sel_out;
      prev_dyn_q <= !static_mode;
      if (static_mode) begin
        len_q   <= '0;
        armed_q <= 1'b0;
      end else if (sel_moved) begin
        len_q   <= 16'd1;
        armed_q <= 1'b1;
      end else begin
        len_q   <= len_q + 16'd1;
      end
    end
  end

  // R2: one select line, all select pins driven, in scan mode
  a_r2_one_select: assert property (@(posedge clk) disable iff (!rst_ni)
    !static_mode |-> ($countones(sel_out) == 1 && sel_oe == '1));

  // R2: rotation order
  a_r2_rotate: assert property (@(posedge clk) disable iff (!rst_ni)
    sel_moved |-> sel_out == {prev_sel_q[N_DEV-2:0], prev_sel_q[N_DEV-1]});

  // R2: window length
  a_r2_window: assert property (@(posedge clk) disable iff (!rst_ni)
    (sel_moved && armed_q) |-> len_q == 16'(SLOT_CYCLES));

  // R3: direction write reaches io_oe in the next cycle
  a_r3_dir_oe: assert property (@(posedge clk) disable iff (!rst_ni)
    (bus_req && bus_we && bus_addr == '0) |=> io_oe == $past(wd_io));

  // R9: read data valid exactly one cycle after a read request
  a_r9_rvalid: assert property (@(posedge clk) disable iff (!rst_ni)
    (bus_req && !bus_we) |=> bus_rvalid);
  a_r9_no_rvalid: assert property (@(posedge clk) disable iff (!rst_ni)
    !(bus_req && !bus_we) |=> !bus_rvalid);

  // R8: interrupt only releases after a read
  a_r8_irq_release: assert property (@(posedge clk) disable iff (!rst_ni)
    $fell(irq_pd) |-> $past(bus_req && !bus_we));
endmodule

bind lio_port_ctrl lio_port_ctrl_chk #(
  .N_IO(N_IO), .N_DEV(N_DEV), .SLOT_CYCLES(SLOT_CYCLES)
) u_chk (
  .clk(clk), .rst_ni(rst_ni), .static_mode(static_mode),
  .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
  .wd_io(bus_wdata[N_IO-1:0]), .bus_rvalid(bus_rvalid),
  .sel_out(sel_out), .sel_oe(sel_oe), .io_oe(io_oe), .irq_pd(irq_pd)
);

// File: tb/lio_port_ctrl_bench.sv
module lio_port_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_req = 1'b0, bus_we = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        bus_rvalid;
  logic [11:0] io_in, io_out, io_oe;
  logic [3:0]  sel_in = 4'hC;
  logic [3:0]  sel_out, sel_oe;
  logic        irq_pd;

  logic [11:0] dev_val [4];
  logic [11:0] st_io = 12'h30A;
  logic        bench_static = 1'b0;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  typedef struct { logic [15:0] exp; string tag; } item_t;
  item_t sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  lio_port_ctrl u_lio_port_ctrl (
    .clk(clk), .rst_n(rst_n),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .io_in(io_in), .io_out(io_out), .io_oe(io_oe),
    .sel_in(sel_in), .sel_out(sel_out), .sel_oe(sel_oe), .irq_pd(irq_pd)
  );

  // External devices: the selected one drives the io pins
  always_comb begin
    io_in = '0;
    if (bench_static) io_in = st_io;
    else begin
      case (sel_out)
        4'b0001: io_in = dev_val[0];
        4'b0010: io_in = dev_val[1];
        4'b0100: io_in = dev_val[2];
        4'b1000: io_in = dev_val[3];
        default: io_in = '0;
      endcase
    end
  end

  function automatic void check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endfunction

  function automatic void report();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endfunction

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(logic [2:0] a, logic [15:0] d);
    @(negedge clk);
    bus_req = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 0; bus_we = 0;
  endtask

  // Driver: pushes the expected read result, then issues the read
  task automatic bus_read(logic [2:0] a, logic [15:0] exp, string tag);
    item_t it;
    it.exp = exp; it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk);
    bus_req = 1; bus_we = 0; bus_addr = a;
    @(negedge clk);
    bus_req = 0;
  endtask

  // Monitor: compares each returned read against the scoreboard
  always @(negedge clk) begin
    if (rst_n && bus_rvalid) begin
      if (sb_q.size() == 0) check("R9 unexpected rvalid", 1, 0);
      else begin
        item_t it;
        it = sb_q.pop_front();
        check(it.tag, {16'h0, bus_rdata}, {16'h0, it.exp});
      end
    end
  end

  initial begin
    for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    dev_val[0] = 12'h111; dev_val[1] = 12'h222;
    dev_val[2] = 12'h444; dev_val[3] = 12'h888;
    tick(3);
    // R1 reset state
    check("R1 sel_out", {28'h0, sel_out}, 32'h1);
    check("R1 sel_oe",  {28'h0, sel_oe},  32'hF);
    check("R1 io_oe",   {20'h0, io_oe},   32'h0);
    check("R1 irq_pd",  {31'h0, irq_pd},  32'h0);
    rst_n = 1;
    tick(3);
    bus_read(3'd0, 16'h0000, "R1 cfg after reset");

    // R2 rotation, aligned to the first clock of device 1
    begin
      int guard = 0;
      while (sel_out != 4'b0010 && guard < 100) begin tick(1); guard++; end
      for (int k = 0; k < 16; k++) begin
        check("R2 rotation", {28'h0, sel_out}, 32'(4'b0001 << ((1 + k / 4) % 4)));
        check("R2 sel_oe", {28'h0, sel_oe}, 32'hF);
        tick(1);
      end
    end

    // R3 direction
    bus_write(3'd0, 16'h00F0);
    check("R3 io_oe", {20'h0, io_oe}, 32'h0F0);
    bus_read(3'd0, 16'h00F0, "R3 cfg readback");

    // R4 per-device transmit words
    bus_write(3'd1, 16'h0123);
    bus_write(3'd2, 16'h0456);
    bus_write(3'd3, 16'h0789);
    bus_write(3'd4, 16'h0ABC);
    for (int n = 0; n < 4; n++) begin
      int guard = 0;
      logic [11:0] pat [4];
      pat[0] = 12'h123; pat[1] = 12'h456; pat[2] = 12'h789; pat[3] = 12'hABC;
      while (sel_out != (4'b0001 << n) && guard < 100) begin tick(1); guard++; end
      check("R4 io_out on outputs", {20'h0, io_out & io_oe}, {20'h0, pat[n] & 12'h0F0});
    end

    // R5 captured inputs, output bits read 0; reads clear pending
    tick(40);
    bus_read(3'd1, 16'h0101, "R5 dev0 capture");
    bus_read(3'd2, 16'h0202, "R5 dev1 capture");
    bus_read(3'd3, 16'h0404, "R5 dev2 capture");
    bus_read(3'd4, 16'h0808, "R5 dev3 capture");
    tick(1);
    check("R8 irq clear after reads", {31'h0, irq_pd}, 32'h0);

    // R8 change on an output pin is ignored
    dev_val[3] = 12'h8A8;
    tick(40);
    check("R8 output pin change ignored", {31'h0, irq_pd}, 32'h0);
    bus_read(3'd4, 16'h0808, "R8 dev3 unchanged");

    // R8 change on an input pin of device 2
    dev_val[2] = 12'h445;
    tick(40);
    check("R8 irq set scan", {31'h0, irq_pd}, 32'h1);
    bus_read(3'd2, 16'h0202, "R8 other device read");
    tick(1);
    check("R8 irq holds", {31'h0, irq_pd}, 32'h1);
    bus_read(3'd3, 16'h0405, "R8 dev2 new capture");
    tick(1);
    check("R8 irq cleared by read", {31'h0, irq_pd}, 32'h0);

    // Direct mode
    bus_write(3'd0, 16'h80F0);
    bench_static = 1;
    bus_write(3'd1, 16'h0ABC);
    bus_write(3'd2, 16'h0003);
    bus_write(3'd3, 16'h0002);
    check("R7 io_out direct", {20'h0, io_out}, 32'hABC);
    check("R6 sel_oe direct", {28'h0, sel_oe}, 32'h3);
    check("R6 sel_out direct", {28'h0, sel_out}, 32'h2);
    tick(6);
    bus_read(3'd1, 16'h030A, "R7 io pins read");
    bus_read(3'd3, 16'h000C, "R6 sel pins read");
    bus_read(3'd2, 16'h0003, "R6 sel dir readback");
    bus_read(3'd0, 16'h80F0, "R3 cfg direct readback");
    tick(1);
    check("R8 irq idle direct", {31'h0, irq_pd}, 32'h0);

    st_io = 12'h30B;
    tick(4);
    check("R8 irq io change", {31'h0, irq_pd}, 32'h1);
    bus_read(3'd1, 16'h030B, "R7 io pins new");
    tick(1);
    check("R8 irq cleared io", {31'h0, irq_pd}, 32'h0);

    st_io = 12'h31B;
    tick(6);
    check("R8 output io change ignored", {31'h0, irq_pd}, 32'h0);

    sel_in = 4'h4;
    tick(4);
    check("R8 irq sel change", {31'h0, irq_pd}, 32'h1);
    bus_read(3'd3, 16'h0004, "R6 sel pins new");
    tick(1);
    check("R8 irq cleared sel", {31'h0, irq_pd}, 32'h0);

    // Back to scan mode
    bus_write(3'd0, 16'h00F0);
    bench_static = 0;
    check("R2 sel_out after return", {28'h0, sel_out}, 32'h1);
    check("R2 sel_oe after return", {28'h0, sel_oe}, 32'hF);

    tick(3);
    check("R9 scoreboard drained", 32'(sb_q.size()), 0);
    report();
  end
endmodule